// File: doc/BRIEF.md
# Mailbox Command Transaction Sequencer

This block runs one complete command exchange between a host and an embedded controller that sits behind a byte-wide mailbox. A one-cycle `start` pulse supplies an opcode, an argument count, a response count and up to eight argument bytes. The sequencer first flushes stale mailbox flags. It then sends the opcode and the arguments through the data register, one byte per write. Next it consumes the single acknowledge byte the controller returns and drops it. Last, it gathers the requested reply bytes into an output buffer.

Every byte transfer waits on a FIFO flag in the mailbox status register. That wait is a bounded poll. If a poll hits its limit, the transaction ends with `timeout` raised. For two-byte replies, such as the event-status (0x0C) and external-status (0x11) queries, the block also presents a ready-made 16-bit word.

The mailbox is reached through a simple register port. A read issued in one cycle returns its value on `bus_rdata` in the next cycle. A write takes effect at the clock edge where `bus_wr` is high.

The FSM states are:
- **IDLE**: wait for start.
- **CLR_RD**: read status.
- **CLR_WB**: write the status value back.
- **TXP_RD / TXP_CHK**: poll for transmit room.
- **TX_WR**: write a byte.
- **RXP_RD / RXP_CHK**: poll for a received byte.
- **RX_RD**: read data.
- **RX_ACK**: store the byte and acknowledge it.
- **FIN**: pulse done.

The transitions are:
- IDLE→CLR_RD on start.
- CLR_RD→CLR_WB→TXP_RD.
- TXP_RD→TXP_CHK.
- TXP_CHK→TX_WR when there is room, →FIN on poll expiry, otherwise →TXP_RD.
- TX_WR→RXP_RD after the last argument, otherwise →TXP_RD.
- RXP_RD→RXP_CHK.
- RXP_CHK→RX_RD when a byte is present, →FIN on expiry, otherwise →RXP_RD.
- RX_RD→RX_ACK.
- RX_ACK→FIN after the last response, otherwise →RXP_RD.
- FIN→IDLE.

Top module: `cmd_txn_seq`

## Requirements
- R1: A `start` pulse seen in IDLE latches opcode, counts and argument bytes, clears `timeout` and raises `busy` the next cycle. A `start` pulse while `busy` is high has no effect on the running exchange.
- R2: Each transaction begins by reading the status register (`bus_sel`=2) and writing the identical value back to it.
- R3: The opcode is written to the data register (`bus_sel`=1) first, followed by the argument bytes in buffer order. Argument byte i is `arg_bytes[8i+7:8i]`. Every byte travels in bits 15:8 of the word, with all other bits zero.
- R4: Every data write is preceded by a status read that shows transmit-not-full (status bit 1) set. The status read is repeated while the bit is clear.
- R5: After the last argument, exactly one byte is read as an acknowledge. It is never placed in the response buffer.
- R6: Response byte k is stored in `rsp_bytes[8k+7:8k]` in arrival order. Slots that are not filled are zero, because the buffer is cleared at start.
- R7: Every data read is preceded by a status read showing receive-not-empty (status bit 2) set.
- R8: Every data read is followed in the next cycle by a status write of value 0x4.
- R9: After `POLL_LIMIT` consecutive failed status reads in one poll, `timeout` is set, the transaction is abandoned and no further mailbox access occurs. `timeout` stays set until the next accepted start.
- R10: Argument and response counts above `MAX_BYTES` are treated as `MAX_BYTES`.
- R11: `result16` equals response byte 0 in bits 15:8 and response byte 1 in bits 7:0.
- R12: `done` is a one-cycle pulse at the end of every transaction, whether it completed or timed out. `busy` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, honoured only in IDLE |
| opcode | input | 8 | Command opcode |
| arg_cnt | input | CW | Number of argument bytes |
| rsp_cnt | input | CW | Number of response bytes |
| arg_bytes | input | 8*MAX_BYTES | Argument buffer, byte i at [8i+7:8i] |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| timeout | output | 1 | Last transaction ended on a poll limit |
| rsp_bytes | output | 8*MAX_BYTES | Response buffer, byte k at [8k+7:8k] |
| result16 | output | 16 | {byte0, byte1} of the response |
| bus_rd | output | 1 | Mailbox register read strobe |
| bus_wr | output | 1 | Mailbox register write strobe |
| bus_sel | output | 2 | Register select: 1 data, 2 status |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid one cycle after `bus_rd` |

## Verification
The assertions assume a mailbox that answers every read exactly one cycle later on `bus_rdata`. They also assume that `bus_rdata` holds its value until the next read. The gating checks compare the previous cycle's `bus_rdata` flag bits with the current strobe, so they depend on this. The bench's mailbox model honours that latency, keeps its read register steady between reads, and never issues stall counts or empty queues that the counts cannot reach. The deliberate timeout cases are the only exceptions. `start` is driven on the falling edge as a single-cycle pulse.

// File: rtl/cts_pkg.sv
package cts_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CLR_RD,
        S_CLR_WB,
        S_TXP_RD,
        S_TXP_CHK,
        S_TX_WR,
        S_RXP_RD,
        S_RXP_CHK,
        S_RX_RD,
        S_RX_ACK,
        S_FIN
    } cts_state_e;

    // Mailbox register selects (decoded by the mailbox)
    localparam logic [1:0] SEL_INTR = 2'd0;
    localparam logic [1:0] SEL_DATA = 2'd1;
    localparam logic [1:0] SEL_STAT = 2'd2;

    // Status register bit positions
    localparam int ST_TXE  = 0;
    localparam int ST_TXNF = 1;
    localparam int ST_RXNE = 2;
    localparam int ST_RXOV = 3;

    // Byte lane inside the data word
    localparam int LANE_LSB = 8;

endpackage

// File: rtl/cts_poll_ctr.sv
module cts_poll_ctr #(
    parameter int LIMIT = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic miss,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!active) begin
            cnt <= '0;
        end else if (miss) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = miss && (cnt == W'(LIMIT - 1));

    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt < W'(LIMIT))); // R9

endmodule

// File: rtl/cts_arg_mux.sv
module cts_arg_mux #(
    parameter int MAXB = 8,
    parameter int CW   = $clog2(MAXB + 1)
) (
    input  logic [8*MAXB-1:0] args,
    input  logic [7:0]        opcode,
    input  logic [CW-1:0]     idx,
    output logic [7:0]        byte_out
);
    always_comb begin
        byte_out = opcode;
        for (int i = 0; i < MAXB; i++) begin
            if (idx == CW'(i + 1)) begin
                byte_out = args[8*i +: 8];
            end
        end
    end
endmodule

// File: rtl/cts_rsp_buf.sv
module cts_rsp_buf #(
    parameter int MAXB = 8,
    parameter int CW   = $clog2(MAXB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [CW-1:0]     wr_idx,
    input  logic [7:0]        wr_byte,
    output logic [8*MAXB-1:0] buf_flat,
    output logic [15:0]       result16
);
    genvar g;
    generate
        for (g = 0; g < MAXB; g++) begin : g_slot
            logic [7:0] slot;
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    slot <= '0;
                end else if (wr_en && (wr_idx == CW'(g))) begin
                    slot <= wr_byte;
                end
            end
            assign buf_flat[8*g +: 8] = slot;
        end
    endgenerate

    // first byte received is the upper half
    assign result16 = {buf_flat[7:0], buf_flat[15:8]};
endmodule

// File: rtl/cmd_txn_seq.sv
module cmd_txn_seq
    import cts_pkg::*;
#(
    parameter int MAX_BYTES  = 8,
    parameter int POLL_LIMIT = 10000,
    parameter int DATA_W     = 32,
    parameter int CW         = $clog2(MAX_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [7:0]             opcode,
    input  logic [CW-1:0]          arg_cnt,
    input  logic [CW-1:0]          rsp_cnt,
    input  logic [8*MAX_BYTES-1:0] arg_bytes,
    output logic                   busy,
    output logic                   done,
    output logic                   timeout,
    output logic [8*MAX_BYTES-1:0] rsp_bytes,
    output logic [15:0]            result16,
    output logic                   bus_rd,
    output logic                   bus_wr,
    output logic [1:0]             bus_sel,
    output logic [DATA_W-1:0]      bus_wdata,
    input  logic [DATA_W-1:0]      bus_rdata
);
    localparam logic [CW-1:0] MAXC = CW'(MAX_BYTES);
    localparam int PAD_W = DATA_W - 16;

    cts_state_e state, state_nx;

    logic [7:0]             op_q;
    logic [8*MAX_BYTES-1:0] args_q;
    logic [CW-1:0]          arg_n, rsp_n;
    logic [CW-1:0]          tx_idx, rx_idx;
    logic                   timeout_q;
    logic                   accept;
    logic                   txnf, rxne;
    logic                   tx_last, rx_last;
    logic                   poll_active, poll_miss, poll_expired;
    logic [7:0]             tx_byte;
    logic                   buf_wr;
    logic [CW-1:0]          buf_idx;

    function automatic logic [CW-1:0] sat_cnt(input logic [CW-1:0] c);
        return (c > MAXC) ? MAXC : c;
    endfunction

    assign accept  = (state == S_IDLE) && start;
    assign txnf    = bus_rdata[ST_TXNF];
    assign rxne    = bus_rdata[ST_RXNE];
    assign tx_last = (tx_idx == arg_n);
    assign rx_last = (rx_idx == rsp_n);

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (start) state_nx = S_CLR_RD;
            S_CLR_RD:  state_nx = S_CLR_WB;
            S_CLR_WB:  state_nx = S_TXP_RD;
            S_TXP_RD:  state_nx = S_TXP_CHK;
            S_TXP_CHK: begin
                if (txnf)              state_nx = S_TX_WR;
                else if (poll_expired) state_nx = S_FIN;
                else                   state_nx = S_TXP_RD;
            end
            S_TX_WR:   state_nx = tx_last ? S_RXP_RD : S_TXP_RD;
            S_RXP_RD:  state_nx = S_RXP_CHK;
            S_RXP_CHK: begin
                if (rxne)              state_nx = S_RX_RD;
                else if (poll_expired) state_nx = S_FIN;
                else                   state_nx = S_RXP_RD;
            end
            S_RX_RD:   state_nx = S_RX_ACK;
            S_RX_ACK:  state_nx = rx_last ? S_FIN : S_RXP_RD;
            S_FIN:     state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // ---------------- request latch and byte counters ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= '0;
            args_q    <= '0;
            arg_n     <= '0;
            rsp_n     <= '0;
            tx_idx    <= '0;
            rx_idx    <= '0;
            timeout_q <= 1'b0;
        end else begin
            if (accept) begin
                op_q      <= opcode;
                args_q    <= arg_bytes;
                arg_n     <= sat_cnt(arg_cnt);
                rsp_n     <= sat_cnt(rsp_cnt);
                tx_idx    <= '0;
                rx_idx    <= '0;
                timeout_q <= 1'b0;
            end
            if (state == S_TX_WR && !tx_last) begin
                tx_idx <= tx_idx + 1'b1;
            end
            if (state == S_RX_ACK && !rx_last) begin
                rx_idx <= rx_idx + 1'b1;
            end
            if (poll_expired) begin
                timeout_q <= 1'b1;
            end
        end
    end

    // ---------------- mailbox outputs ----------------
    always_comb begin
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_sel   = SEL_INTR;
        bus_wdata = '0;
        unique case (state)
            S_CLR_RD, S_TXP_RD, S_RXP_RD: begin
                bus_rd  = 1'b1;
                bus_sel = SEL_STAT;
            end
            S_CLR_WB: begin
                bus_wr    = 1'b1;
                bus_sel   = SEL_STAT;
                bus_wdata = bus_rdata;
            end
            S_TX_WR: begin
                bus_wr    = 1'b1;
                bus_sel   = SEL_DATA;
                bus_wdata = {{PAD_W{1'b0}}, tx_byte, 8'h00};
            end
            S_RX_RD: begin
                bus_rd  = 1'b1;
                bus_sel = SEL_DATA;
            end
            S_RX_ACK: begin
                bus_wr    = 1'b1;
                bus_sel   = SEL_STAT;
                bus_wdata = DATA_W'(1) << ST_RXNE;
            end
            default: begin
                bus_rd = 1'b0;
            end
        endcase
    end

    assign busy    = (state != S_IDLE);
    assign done    = (state == S_FIN);
    assign timeout = timeout_q;

    assign poll_active = (state == S_TXP_RD) || (state == S_TXP_CHK) ||
                         (state == S_RXP_RD) || (state == S_RXP_CHK);
    assign poll_miss   = ((state == S_TXP_CHK) && !txnf) ||
                         ((state == S_RXP_CHK) && !rxne);

    // acknowledge byte sits at rx_idx 0 and is dropped
    assign buf_wr  = (state == S_RX_ACK) && (rx_idx != '0);
    assign buf_idx = rx_idx - 1'b1;

    cts_poll_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (poll_active),
        .miss    (poll_miss),
        .expired (poll_expired)
    );

    cts_arg_mux #(.MAXB(MAX_BYTES), .CW(CW)) u_mux (
        .args     (args_q),
        .opcode   (op_q),
        .idx      (tx_idx),
        .byte_out (tx_byte)
    );

    cts_rsp_buf #(.MAXB(MAX_BYTES), .CW(CW)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (accept),
        .wr_en    (buf_wr),
        .wr_idx   (buf_idx),
        .wr_byte  (bus_rdata[LANE_LSB +: 8]),
        .buf_flat (rsp_bytes),
        .result16 (result16)
    );

    // ---------------- assertions ----------------
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(op_q)); // R1

    AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == SEL_DATA) |-> $past(bus_rdata[ST_TXNF])); // R4

    AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_sel == SEL_DATA) |-> $past(bus_rdata[ST_RXNE])); // R7

    AST_RX_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_sel == SEL_DATA) |=>
        (bus_wr && bus_sel == SEL_STAT && bus_wdata == (DATA_W'(1) << ST_RXNE))); // R8

    AST_TIMEOUT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> done); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy && !bus_rd && !bus_wr)); // R12

endmodule

// File: tb/tb_cmd_txn_seq.sv
module tb_cmd_txn_seq;
    localparam int MAXB = 8;
    localparam int PL   = 24;
    localparam int CW   = 4;
    localparam int NV   = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic              rst_n;
    logic              start;
    logic [7:0]        opcode;
    logic [CW-1:0]     arg_cnt, rsp_cnt;
    logic [8*MAXB-1:0] arg_bytes;
    logic              busy, done, timeout;
    logic [8*MAXB-1:0] rsp_bytes;
    logic [15:0]       result16;
    logic              bus_rd, bus_wr;
    logic [1:0]        bus_sel;
    logic [31:0]       bus_wdata;
    logic [31:0]       bus_rdata;

    cmd_txn_seq #(.MAX_BYTES(MAXB), .POLL_LIMIT(PL), .DATA_W(32), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .arg_cnt(arg_cnt), .rsp_cnt(rsp_cnt), .arg_bytes(arg_bytes),
        .busy(busy), .done(done), .timeout(timeout),
        .rsp_bytes(rsp_bytes), .result16(result16),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // ---------------- mailbox model ----------------
    logic [7:0]  rxq [0:31];
    logic [31:0] logd [0:63];
    logic [1:0]  logs [0:63];
    int rq_n, rp, ln, stall_left, stat_rd_n, done_n;
    logic ov;

    always @(posedge clk) begin
        if (bus_rd && bus_sel == 2'd2) begin
            if (ln > 0) stat_rd_n = stat_rd_n + 1;
            if (stall_left > 0 && ln > 0) begin
                stall_left = stall_left - 1;
                bus_rdata <= 32'h0;
            end else begin
                bus_rdata <= {28'h0, ov, (rp < rq_n), 1'b1, 1'b1};
            end
        end else if (bus_rd && bus_sel == 2'd1) begin
            bus_rdata <= {16'h0, rxq[rp[4:0]], 8'h00};
            rp = rp + 1;
        end
        if (bus_wr) begin
            if (ln < 64) begin
                logd[ln] = bus_wdata;
                logs[ln] = bus_sel;
            end
            ln = ln + 1;
            if (bus_sel == 2'd2 && bus_wdata[3]) ov = 1'b0;
        end
        if (done) done_n = done_n + 1;
    end

    // ---------------- checking ----------------
    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // vector table
    localparam logic [7:0]  V_OP  [NV] = '{8'h0C, 8'h11, 8'h24, 8'h41, 8'h40, 8'h12};
    localparam logic [3:0]  V_A   [NV] = '{4'd0, 4'd0, 4'd1, 4'd3, 4'd2, 4'd12};
    localparam logic [3:0]  V_R   [NV] = '{4'd2, 4'd2, 4'd0, 4'd1, 4'd4, 4'd15};
    localparam logic [63:0] V_ARG [NV] = '{64'h0, 64'h0, 64'h7F,
                                           64'h33_22_11, 64'h06_05,
                                           64'h88_77_66_55_44_33_22_11};
    localparam logic [63:0] V_RSP [NV] = '{64'h34_12, 64'h0F_A5, 64'h0,
                                           64'h99, 64'h04_03_02_01,
                                           64'hF8_E7_D6_C5_B4_A3_92_81};
    localparam int          V_STL [NV] = '{0, 3, 0, 2, 5, 0};
    localparam logic        V_OV  [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};

    task automatic mb_load(input int nrsp, input logic [63:0] rsp, input bit with_ack,
                           input int stall, input logic ovi);
        ln = 0; rp = 0; stat_rd_n = 0; done_n = 0;
        stall_left = stall; ov = ovi;
        rxq[0] = 8'hAC;
        for (int i = 0; i < 8; i++) rxq[i+1] = rsp[8*i +: 8];
        rq_n = with_ack ? (1 + nrsp) : 0;
    endtask

    // returns 1 on normal completion
    task automatic run(input logic [7:0] op, input logic [3:0] a, input logic [3:0] r,
                       input logic [63:0] args, input bit intrude, output bit ok);
        int cyc;
        @(negedge clk);
        start = 1'b1; opcode = op; arg_cnt = a; rsp_cnt = r; arg_bytes = args;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R1 busy after start", 64'(busy), 64'd1);
        cyc = 0;
        ok  = 1'b1;
        while (done !== 1'b1) begin
            @(negedge clk);
            cyc++;
            if (intrude && cyc == 4) begin
                start = 1'b1; opcode = 8'h55; arg_cnt = 4'd3; rsp_cnt = 4'd0;
            end else if (intrude && cyc == 5) begin
                start = 1'b0;
            end
            if (cyc > 3000) begin
                chk(1'b0, "watchdog", 64'(cyc), 64'd0);
                ok = 1'b0;
                break;
            end
        end
    endtask

    task automatic check_normal(input logic [7:0] op, input logic [3:0] a, input logic [3:0] r,
                                input logic [63:0] args, input logic [63:0] rsp, input logic ovi);
        int ae, re, k;
        logic [63:0] exp_buf;
        ae = (a > 8) ? 8 : int'(a);
        re = (r > 8) ? 8 : int'(r);
        exp_buf = '0;
        for (int i = 0; i < 8; i++) if (i < re) exp_buf[8*i +: 8] = rsp[8*i +: 8];
        chk(timeout === 1'b0, "R9 no timeout", 64'(timeout), 64'd0);
        chk(logs[0] == 2'd2 && logd[0] == {28'h0, ovi, 3'b111}, "R2 clear writeback",
            64'(logd[0]), 64'({ovi, 3'b111}));
        chk(ln == 3 + ae + re, "R10 access count", 64'(ln), 64'(3 + ae + re));
        chk(logs[1] == 2'd1 && logd[1] == {16'h0, op, 8'h00}, "R3 opcode first",
            64'(logd[1]), 64'({op, 8'h00}));
        for (int i = 0; i < ae; i++)
            chk(logs[2+i] == 2'd1 && logd[2+i] == {16'h0, args[8*i +: 8], 8'h00},
                "R3 arg order", 64'(logd[2+i]), 64'({args[8*i +: 8], 8'h00}));
        k = 2 + ae;
        for (int i = 0; i <= re; i++)
            chk(logs[k+i] == 2'd2 && logd[k+i] == 32'h4, "R8 rx ack write",
                64'(logd[k+i]), 64'h4);
        chk(rp == 1 + re, "R5 one ack plus responses read", 64'(rp), 64'(1 + re));
        chk(rsp_bytes == exp_buf, "R6 response buffer", rsp_bytes, exp_buf);
        chk(result16 == {exp_buf[7:0], exp_buf[15:8]}, "R11 result16",
            64'(result16), 64'({exp_buf[7:0], exp_buf[15:8]}));
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R12 done pulse then idle",
            64'({done, busy}), 64'd0);
    endtask

    initial begin
        bit ok;
        rst_n = 1'b0; start = 1'b0; opcode = '0; arg_cnt = '0; rsp_cnt = '0; arg_bytes = '0;
        bus_rdata = '0;
        mb_load(0, 64'h0, 1'b0, 0, 1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && timeout === 1'b0 && bus_rd === 1'b0 &&
            bus_wr === 1'b0 && rsp_bytes === '0, "R12 reset state",
            64'({busy, done, timeout, bus_rd, bus_wr}), 64'd0);

        // table walk (R3 R4 R5 R6 R7 R8 R10 R11)
        for (int v = 0; v < NV; v++) begin
            mb_load((V_R[v] > 8) ? 8 : int'(V_R[v]), V_RSP[v], 1'b1, V_STL[v], V_OV[v]);
            run(V_OP[v], V_A[v], V_R[v], V_ARG[v], 1'b0, ok);
            if (ok) check_normal(V_OP[v], V_A[v], V_R[v], V_ARG[v], V_RSP[v], V_OV[v]);
            chk(V_STL[v] == 0 || stall_left == 0, "R4 R7 stalls absorbed",
                64'(stall_left), 64'd0);
        end

        // R1: start while busy ignored
        mb_load(2, 64'h55_66, 1'b1, 0, 1'b0);
        run(8'h0C, 4'd0, 4'd2, 64'h0, 1'b1, ok);
        if (ok) check_normal(8'h0C, 4'd0, 4'd2, 64'h0, 64'h55_66, 1'b0);
        repeat (4) @(negedge clk);
        chk(done_n == 1 && busy === 1'b0, "R1 intruding start ignored",
            64'(done_n), 64'd1);

        // R9: transmit poll expires
        mb_load(0, 64'h0, 1'b1, 1000, 1'b0);
        run(8'h30, 4'd1, 4'd0, 64'h1, 1'b0, ok);
        chk(timeout === 1'b1, "R9 tx timeout flag", 64'(timeout), 64'd1);
        chk(ln == 1, "R9 no data write after tx timeout", 64'(ln), 64'd1);
        chk(stat_rd_n == PL, "R4 R9 tx poll count", 64'(stat_rd_n), 64'(PL));
        repeat (5) @(negedge clk);
        chk(busy === 1'b0 && ln == 1 && timeout === 1'b1, "R9 idle and flag held",
            64'({busy, timeout}), 64'd1);

        // R9: receive poll expires (no acknowledge ever arrives)
        mb_load(0, 64'h0, 1'b0, 0, 1'b0);
        run(8'h11, 4'd0, 4'd2, 64'h0, 1'b0, ok);
        chk(timeout === 1'b1, "R9 rx timeout flag", 64'(timeout), 64'd1);
        chk(logd[0] == 32'h3 && ln == 2, "R2 R9 clear and opcode only",
            64'(ln), 64'd2);
        chk(stat_rd_n == PL + 1, "R7 R9 rx poll count", 64'(stat_rd_n), 64'(PL + 1));
        chk(rp == 0, "R7 no data read without rxne", 64'(rp), 64'd0);

        // R9: next start clears timeout
        mb_load(2, 64'hBE_EF, 1'b1, 0, 1'b0);
        run(8'h0C, 4'd0, 4'd2, 64'h0, 1'b0, ok);
        if (ok) check_normal(8'h0C, 4'd0, 4'd2, 64'h0, 64'hBE_EF, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // global watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule